// File: doc/BRIEF.md
# Floating-Point Structural Hazard Tracker

This block sits beside the issue stage of an in-order core. It tracks three shared floating-point resources: the multiply pipe, the add pipe and the divide/square-root unit. Each cycle the issue logic presents the class of the next candidate instruction. The tracker answers with a single can-issue flag. When the issue logic asserts the issue strobe while that flag is high, the tracker records the cycles that class will hold each resource.

The multiply and add pipes are each modeled by a reservation shift register. Bit k of the register means the pipe is held k cycles from now. A candidate may issue only if none of the cycles it needs is already held. The divider completes out of order and keeps no per-cycle map. A small two-state machine with a down-counter tracks it instead. It has two states. In DV_IDLE the unit is free. In DV_BUSY the counter holds the number of busy cycles that remain. The transition IDLE_TO_BUSY fires on an accepted divide and loads the class's hold count. The transition BUSY_TO_IDLE fires when the counter reaches 1. Otherwise the machine stays in DV_BUSY (BUSY_HOLD), counting down. While the divider is busy, only other divides are blocked.

Top module: `fpu_haz_tracker`

## Requirements
- R1: After reset, every busy output is 0 and can_issue is 1 for every class code 0 to 7, with issue held low.
- R2: Class code 1 (add, compare, convert, copy, load constant) holds the add pipe only in its issue cycle. add_busy is 1 in the cycle of an accepted issue of this class. The same class can issue again in the next cycle.
- R3: Class code 2 (single multiply or multiply-accumulate) holds the multiply pipe only in its issue cycle. Two of these can issue in consecutive cycles.
- R4: Class code 3 (double multiply or multiply-accumulate) holds the multiply pipe in its issue cycle and 3 more cycles. mul_busy is 1 in all four. Codes 2 and 5 are blocked in the 3 extra cycles, and code 2 can issue in the 4th cycle after issue.
- R5: During the extra cycles of a code 3 instruction, classes that do not use the multiply pipe (codes 0, 1, 6, 7) still see can_issue high.
- R6: Class code 4 (double fused multiply-add) holds the multiply pipe in its issue cycle and 4 more cycles.
- R7: Class code 5 (vector multiply) holds the multiply pipe in 2 consecutive cycles, starting with the issue cycle.
- R8: Class code 6 (single divide) holds the divider in its issue cycle and 13 more cycles. In those cycles div_busy is 1 and codes 6 and 7 are blocked.
- R9: Class code 7 (double divide) holds the divider in its issue cycle and 28 more cycles.
- R10: A busy divider does not block codes 1 to 5.
- R11: An issue strobe while can_issue is 0 reserves nothing and does not restart a running reservation.
- R12: Class code 0 (no floating-point resource) always has can_issue high and never sets a busy flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_class | input | 3 | Class code of the candidate instruction |
| issue | input | 1 | Issue strobe; it takes effect only while can_issue is 1 |
| can_issue | output | 1 | Every resource the candidate needs is free in every cycle it would hold that resource |
| mul_busy | output | 1 | Multiply pipe held this cycle, either by an earlier issue or by this cycle's accepted issue |
| add_busy | output | 1 | Add pipe held this cycle |
| div_busy | output | 1 | Divider held this cycle |

## Verification
The hardest case to reach is the tail of a reservation. This is the last extra cycle of a double multiply, or the final count of a divide. There a class that needs two consecutive cycles must still be refused, and a strobe that is refused must leave no trace. The bench issues the long-holding class and then walks cycle by cycle through its hold window. In each cycle it presents a different candidate: a blocked multiply, a free add, a refused vector multiply with the strobe high, and a refused divide in every busy cycle. It then confirms that the resource frees on exactly the cycle the hold count predicts.

// File: rtl/fpu_haz_pkg.sv
package fpu_haz_pkg;
    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_ADD  = 3'd1,
        FC_MULS = 3'd2,
        FC_MULD = 3'd3,
        FC_FMAD = 3'd4,
        FC_VMUL = 3'd5,
        FC_DIVS = 3'd6,
        FC_DIVD = 3'd7
    } fpu_class_e;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_BUSY = 1'b1
    } div_state_e;
endpackage

// File: rtl/fpu_haz_decode.sv
module fpu_haz_decode
    import fpu_haz_pkg::*;
#(
    parameter int MW = 5,
    parameter int AW = 1,
    parameter int CW = 5,
    parameter int MULD_EXTRA = 3,
    parameter int FMAD_EXTRA = 4,
    parameter int VMUL_CYC = 2,
    parameter int ADD_CYC = 1,
    parameter int DIVS_EXTRA = 13,
    parameter int DIVD_EXTRA = 28
) (
    input  logic [2:0]    cand_i,
    output logic [MW-1:0] mul_mask_o,
    output logic [AW-1:0] add_mask_o,
    output logic          div_req_o,
    output logic [CW-1:0] div_load_o
);
    function automatic logic [MW-1:0] mul_run(int n);
        logic [MW-1:0] r;
        for (int i = 0; i < MW; i++) r[i] = (i < n);
        return r;
    endfunction

    function automatic logic [AW-1:0] add_run(int n);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = (i < n);
        return r;
    endfunction

    fpu_class_e cls;
    assign cls = fpu_class_e'(cand_i);

    always_comb begin
        mul_mask_o = '0;
        add_mask_o = '0;
        div_req_o  = 1'b0;
        div_load_o = '0;
        unique case (cls)
            FC_NONE: ;
            FC_ADD:  add_mask_o = add_run(ADD_CYC);
            FC_MULS: mul_mask_o = mul_run(1);
            FC_MULD: mul_mask_o = mul_run(MULD_EXTRA + 1);
            FC_FMAD: mul_mask_o = mul_run(FMAD_EXTRA + 1);
            FC_VMUL: mul_mask_o = mul_run(VMUL_CYC);
            FC_DIVS: begin
                div_req_o  = 1'b1;
                div_load_o = CW'(DIVS_EXTRA);
            end
            FC_DIVD: begin
                div_req_o  = 1'b1;
                div_load_o = CW'(DIVD_EXTRA);
            end
        endcase
    end
endmodule

// File: rtl/fpu_resv_shreg.sv
module fpu_resv_shreg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_mask,
    input  logic         take,
    output logic         conflict,
    output logic         busy_now
);
    logic [W-1:0] res_q;
    logic [W-1:0] res_d;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_slot
            if (k < W - 1) begin : g_shift
                assign res_d[k] = res_q[k+1] | (take & req_mask[k+1]);
            end else begin : g_top
                assign res_d[k] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign conflict = |(res_q & req_mask);
    assign busy_now = res_q[0] | (take & req_mask[0]);

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((res_q & req_mask) == '0));

    generate
        if (W > 1) begin : g_adv
            // R7
            slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
                res_q[1] |=> busy_now);
        end
    endgenerate
endmodule

// File: rtl/fpu_div_track.sv
module fpu_div_track
    import fpu_haz_pkg::*;
#(
    parameter int CW = 5,
    parameter int MAXH = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    output logic          held
);
    div_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DV_IDLE: if (start && load != '0) begin
                st_d  = DV_BUSY;
                cnt_d = load;
            end
            DV_BUSY: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CW'(1)) st_d = DV_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DV_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign held = (st_q == DV_BUSY);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= MAXH);

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !start);

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && cnt_q > CW'(1)) |=> (held && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fpu_haz_tracker.sv
module fpu_haz_tracker #(
    parameter int MULD_EXTRA = 3,
    parameter int FMAD_EXTRA = 4,
    parameter int VMUL_CYC = 2,
    parameter int ADD_CYC = 1,
    parameter int DIVS_EXTRA = 13,
    parameter int DIVD_EXTRA = 28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cand_class,
    input  logic       issue,
    output logic       can_issue,
    output logic       mul_busy,
    output logic       add_busy,
    output logic       div_busy
);
    localparam int MW0 = (MULD_EXTRA > FMAD_EXTRA) ? MULD_EXTRA : FMAD_EXTRA;
    localparam int MW  = ((MW0 + 1) > VMUL_CYC) ? (MW0 + 1) : VMUL_CYC;
    localparam int AW  = ADD_CYC;
    localparam int DMX = (DIVD_EXTRA > DIVS_EXTRA) ? DIVD_EXTRA : DIVS_EXTRA;
    localparam int CW  = $clog2(DMX + 1);

    logic [MW-1:0] mul_mask;
    logic [AW-1:0] add_mask;
    logic          div_req;
    logic [CW-1:0] div_load;
    logic          mul_conf, add_conf, div_held, accept;

    fpu_haz_decode #(
        .MW(MW), .AW(AW), .CW(CW),
        .MULD_EXTRA(MULD_EXTRA), .FMAD_EXTRA(FMAD_EXTRA), .VMUL_CYC(VMUL_CYC),
        .ADD_CYC(ADD_CYC), .DIVS_EXTRA(DIVS_EXTRA), .DIVD_EXTRA(DIVD_EXTRA)
    ) u_dec (
        .cand_i(cand_class), .mul_mask_o(mul_mask), .add_mask_o(add_mask),
        .div_req_o(div_req), .div_load_o(div_load)
    );

    fpu_resv_shreg #(.W(MW)) u_mul (
        .clk(clk), .rst_n(rst_n), .req_mask(mul_mask), .take(accept),
        .conflict(mul_conf), .busy_now(mul_busy)
    );

    fpu_resv_shreg #(.W(AW)) u_add (
        .clk(clk), .rst_n(rst_n), .req_mask(add_mask), .take(accept),
        .conflict(add_conf), .busy_now(add_busy)
    );

    fpu_div_track #(.CW(CW), .MAXH(DMX)) u_div (
        .clk(clk), .rst_n(rst_n), .start(accept & div_req), .load(div_load),
        .held(div_held)
    );

    assign can_issue = !mul_conf && !add_conf && !(div_req && div_held);
    assign accept    = issue && can_issue;
    assign div_busy  = div_held | (accept & div_req);

    // R10
    div_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_held && !div_req && !mul_conf && !add_conf) |-> can_issue);

    // R12
    none_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_class == 3'd0) |-> can_issue);
endmodule

// File: tb/fpu_haz_tracker_test.sv
`timescale 1ns/1ps
module fpu_haz_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cand_class = 3'd0;
    logic       issue = 1'b0;
    logic       can_issue, mul_busy, add_busy, div_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] C_NONE = 3'd0, C_ADD = 3'd1, C_MULS = 3'd2, C_MULD = 3'd3,
                           C_FMAD = 3'd4, C_VMUL = 3'd5, C_DIVS = 3'd6, C_DIVD = 3'd7;

    always #2 clk = ~clk;

    fpu_haz_tracker uut (
        .clk(clk), .rst_n(rst_n), .cand_class(cand_class), .issue(issue),
        .can_issue(can_issue), .mul_busy(mul_busy), .add_busy(add_busy),
        .div_busy(div_busy)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [2:0] c, input logic i);
        @(negedge clk);
        cand_class = c;
        issue = i;
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(C_NONE, 1'b0);
    endtask

    task automatic t_reset();
        for (int c = 0; c < 8; c++) begin
            cyc(3'(c), 1'b0);
            chk(can_issue, 1'b1, "R1 can_issue after reset");
            chk(mul_busy | add_busy | div_busy, 1'b0, "R1 busy after reset");
        end
    endtask

    task automatic t_add();
        cyc(C_ADD, 1'b1);
        chk(can_issue, 1'b1, "R2 add issue");
        chk(add_busy, 1'b1, "R2 add_busy in issue cycle");
        cyc(C_ADD, 1'b1);
        chk(can_issue, 1'b1, "R2 add back to back");
        cyc(C_NONE, 1'b1);
        chk(add_busy, 1'b0, "R2 add_busy cleared");
        chk(can_issue, 1'b1, "R12 none can issue");
        chk(mul_busy | div_busy, 1'b0, "R12 none sets no busy");
        idle(2);
    endtask

    task automatic t_muls();
        cyc(C_MULS, 1'b1);
        chk(can_issue, 1'b1, "R3 muls issue");
        chk(mul_busy, 1'b1, "R3 mul_busy");
        cyc(C_MULS, 1'b1);
        chk(can_issue, 1'b1, "R3 muls back to back");
        cyc(C_NONE, 1'b0);
        chk(mul_busy, 1'b0, "R3 mul free after");
        idle(2);
    endtask

    task automatic t_muld();
        cyc(C_MULD, 1'b1);
        chk(can_issue, 1'b1, "R4 muld issue");
        chk(mul_busy, 1'b1, "R4 mul_busy cycle 0");
        cyc(C_MULS, 1'b1);
        chk(can_issue, 1'b0, "R4 muls blocked cycle 1");
        chk(mul_busy, 1'b1, "R4 mul_busy cycle 1");
        cyc(C_ADD, 1'b1);
        chk(can_issue, 1'b1, "R5 add during muld");
        chk(add_busy, 1'b1, "R5 add accepted during muld");
        chk(mul_busy, 1'b1, "R4 mul_busy cycle 2");
        cyc(C_VMUL, 1'b1);
        chk(can_issue, 1'b0, "R4 vmul blocked cycle 3");
        chk(mul_busy, 1'b1, "R4 mul_busy cycle 3");
        cyc(C_MULS, 1'b0);
        chk(can_issue, 1'b1, "R11 R4 muls free cycle 4 after refused vmul");
        chk(mul_busy, 1'b0, "R11 refused vmul left no hold");
        idle(2);
        cyc(C_MULD, 1'b1);
        cyc(C_DIVS, 1'b0);
        chk(can_issue, 1'b1, "R5 divide free during muld");
        cyc(C_NONE, 1'b0);
        chk(can_issue, 1'b1, "R5 none during muld");
        idle(4);
    endtask

    task automatic t_fmad();
        cyc(C_FMAD, 1'b1);
        chk(can_issue, 1'b1, "R6 fmad issue");
        for (int k = 1; k <= 4; k++) begin
            cyc(C_MULS, 1'b0);
            chk(can_issue, 1'b0, $sformatf("R6 muls blocked cycle %0d", k));
            chk(mul_busy, 1'b1, $sformatf("R6 mul_busy cycle %0d", k));
        end
        cyc(C_MULS, 1'b0);
        chk(can_issue, 1'b1, "R6 muls free cycle 5");
        chk(mul_busy, 1'b0, "R6 mul free cycle 5");
        idle(2);
    endtask

    task automatic t_vmul();
        cyc(C_VMUL, 1'b1);
        chk(can_issue, 1'b1, "R7 vmul issue");
        cyc(C_VMUL, 1'b0);
        chk(can_issue, 1'b0, "R7 vmul blocked next cycle");
        chk(mul_busy, 1'b1, "R7 mul_busy second cycle");
        cyc(C_MULS, 1'b0);
        chk(can_issue, 1'b1, "R7 free third cycle");
        chk(mul_busy, 1'b0, "R7 mul free third cycle");
        idle(2);
    endtask

    task automatic t_divs();
        cyc(C_DIVS, 1'b1);
        chk(can_issue, 1'b1, "R8 divs issue");
        chk(div_busy, 1'b1, "R8 div_busy issue cycle");
        for (int k = 1; k <= 13; k++) begin
            if (k == 3) begin
                cyc(C_MULD, 1'b1);
                chk(can_issue, 1'b1, "R10 muld during divide");
            end else if (k == 9) begin
                cyc(C_ADD, 1'b0);
                chk(can_issue, 1'b1, "R10 add during divide");
            end else begin
                cyc(C_DIVD, 1'b1);
                chk(can_issue, 1'b0, $sformatf("R8 divide blocked cycle %0d", k));
            end
            chk(div_busy, 1'b1, $sformatf("R8 div_busy cycle %0d", k));
        end
        cyc(C_DIVS, 1'b0);
        chk(can_issue, 1'b1, "R11 R8 divider free at cycle 14");
        chk(div_busy, 1'b0, "R8 div_busy clear at cycle 14");
        idle(2);
    endtask

    task automatic t_divd();
        cyc(C_DIVD, 1'b1);
        chk(div_busy, 1'b1, "R9 div_busy issue cycle");
        for (int k = 1; k <= 28; k++) begin
            if (k == 10) begin
                cyc(C_NONE, 1'b1);
                chk(can_issue, 1'b1, "R12 none during divide");
            end else if (k == 20) begin
                cyc(C_VMUL, 1'b1);
                chk(can_issue, 1'b1, "R10 vmul during divide");
            end else begin
                cyc(C_DIVS, 1'b0);
                chk(can_issue, 1'b0, $sformatf("R9 divide blocked cycle %0d", k));
            end
            chk(div_busy, 1'b1, $sformatf("R9 div_busy cycle %0d", k));
        end
        cyc(C_DIVD, 1'b0);
        chk(can_issue, 1'b1, "R9 divider free at cycle 29");
        chk(div_busy, 1'b0, "R9 div_busy clear at cycle 29");
        idle(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_muls();
        t_muld();
        t_fmad();
        t_vmul();
        t_divs();
        t_divd();
        finish_run();
    end
endmodule